// File: doc/BRIEF.md
# Quasi-resonant switching cycle controller

This block is the digital timing core of a valley-switching flyback PWM controller. It watches three synchronous comparator flags: core demagnetisation from the auxiliary winding, primary peak current reached, and a persistent overload or fault. From them it produces one gate-enable output. An on-time begins only when three conditions hold together. The core must have been seen to reset since the last turn-off. A programmable valley delay must have passed since then. A minimum-period clamp, started at the previous turn-on, must have run out. The on-time ends when the current comparator trips.

Two guards stop switching and move the block into a latch-off interval followed by a restart interval. The first is a maximum on-time limit. The second is a fault timer that needs the fault flag to stay high without a break. When the restart interval ends, a fresh first pulse is issued. The same restart interval also follows reset. If no demagnetisation is detected for a long time after turn-off, an internal watchdog stands in for it, so the converter cannot stall. Every time is a parameter counted in clock cycles. Reset is synchronous and active high.

Top module: `qr_cycle_ctrl`

## Requirements
- R1: While `rst` is high, `gate_o` is 0. After release, `gate_o` first rises at the T_RESTART-th rising clock edge that samples `rst` low.
- R2: Two consecutive rising edges of `gate_o` are at least T_MINPER clock edges apart. When the demagnetisation and valley conditions are met earlier, the rise happens exactly T_MINPER edges after the previous rise.
- R3: When `ilim_i` is sampled high while `gate_o` is 1, `gate_o` is 0 after that same edge. `gate_o` stays 1 up to that edge.
- R4: When `demag_i` is sampled high at edge d outside blanking, and the minimum period has expired, `gate_o` rises at edge d+T_VALLEY.
- R5: `demag_i` has no effect in two windows: while `gate_o` is 1, and at the first T_BLANK edges after the edge that drives `gate_o` low.
- R6: If no accepted demagnetisation arrives, a synthetic one is taken at edge f+T_NODEMAG, where f is the turn-off edge. `gate_o` then rises at f+T_NODEMAG+T_VALLEY, provided the minimum period has expired.
- R7: `gate_o` stays 1 for at most T_MAXON consecutive cycles. If `ilim_i` has not ended the on-time, `gate_o` drops at the T_MAXON-th edge after the rise, and latch-off begins.
- R8: The fault trip needs `fault_i` sampled high at T_FAULT consecutive edges while switching is active. `gate_o` is 0 after the trip edge and latch-off begins. A single low sample restarts the count.
- R9: After a trip at edge t, `gate_o` stays 0 whatever the inputs do. It rises again at edge t+T_LATCH+T_RESTART.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| demag_i | input | 1 | Core demagnetisation detected (1 = flux reset) |
| ilim_i | input | 1 | Peak primary current reached (1 = end on-time) |
| fault_i | input | 1 | Overload or fault present (1 = fault) |
| gate_o | output | 1 | Gate enable (1 = power switch on) |

## Verification
The turn-on decision is tried with one pattern per limiting condition. In the first, demagnetisation arrives early, so the minimum-period clamp decides the turn-on. In the second, demagnetisation arrives late, so the valley delay decides it. In the third, no demagnetisation arrives and the watchdog decides it. Demagnetisation pulses placed during the on-time and inside the blanking window are set so that accepting them would move the rise to an earlier edge. Fault bursts one sample short of the limit are set against a full-length burst, and the maximum on-time trip is set against a current-limit turn-off. Stray inputs applied during latch-off check that the restart edge does not move.

// File: rtl/qrc_pkg.sv
package qrc_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ON    = 2'd1,
        ST_LATCH = 2'd2,
        ST_WAIT  = 2'd3
    } phase_e;

    typedef struct packed {
        logic fault;
        logic maxon;
    } trip_t;

    function automatic int cnt_w(input int lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qrc_sat_cnt.sv
module qrc_sat_cnt #(
    parameter int LIMIT      = 1,
    parameter bit START_FULL = 1'b0,
    localparam int W         = qrc_pkg::cnt_w(LIMIT)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] rst_val;

    if (START_FULL) begin : g_full
        assign rst_val = LIM_V;
    end else begin : g_zero
        assign rst_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= rst_val;
        else if (clr)
            cnt <= '0;
        else if (en && (cnt != LIM_V))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/qrc_arm.sv
module qrc_arm #(
    parameter int T_BLANK   = 4,
    parameter int T_VALLEY  = 3,
    parameter int T_NODEMAG = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic in_off,
    input  logic start_on,
    input  logic demag_i,
    output logic ready
);
    localparam int OLIM = T_NODEMAG - 1;
    localparam int VLIM = T_VALLEY - 1;
    localparam int OW   = qrc_pkg::cnt_w(OLIM);
    localparam int VW   = qrc_pkg::cnt_w(VLIM);
    localparam logic [OW-1:0] OEND   = OW'(OLIM);
    localparam logic [OW-1:0] BLANKV = OW'(T_BLANK);
    localparam logic [VW-1:0] VEND   = VW'(VLIM);

    logic [OW-1:0] off_cnt;
    logic [VW-1:0] val_cnt;
    logic          seen_q;
    logic          blanked;
    logic          wd_fire;
    logic          accept;

    // off-time counter: held at zero outside the off phase
    qrc_sat_cnt #(.LIMIT(OLIM), .START_FULL(1'b0)) u_off_cnt (
        .clk(clk), .rst(rst), .clr(!in_off), .en(1'b1), .cnt(off_cnt)
    );

    assign blanked = (off_cnt < BLANKV);
    assign wd_fire = (off_cnt == OEND);
    assign accept  = in_off && !seen_q && ((demag_i && !blanked) || wd_fire);

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= 1'b0;
        else if (start_on)
            seen_q <= 1'b0;
        else if (accept)
            seen_q <= 1'b1;
    end

    // valley delay counter, restarted at each accepted detect
    qrc_sat_cnt #(.LIMIT(VLIM), .START_FULL(1'b0)) u_val_cnt (
        .clk(clk), .rst(rst), .clr(accept), .en(seen_q), .cnt(val_cnt)
    );

    assign ready = seen_q && (val_cnt == VEND);

    assert_valley_R4: assert property (@(posedge clk) disable iff (rst)
        (start_on && in_off) |-> (seen_q && (val_cnt == VEND)));

    assert_on_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        (!in_off && !start_on) |=> $stable(seen_q));

    assert_blank_R5: assert property (@(posedge clk) disable iff (rst)
        (in_off && blanked && !wd_fire && !seen_q) |=> !seen_q);

    assert_wdog_R6: assert property (@(posedge clk) disable iff (rst)
        (in_off && wd_fire && !seen_q) |=> seen_q);
endmodule

// File: rtl/qrc_guard.sv
module qrc_guard
    import qrc_pkg::*;
#(
    parameter int T_MAXON = 12,
    parameter int T_FAULT = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e st,
    input  logic   start_on,
    input  logic   fault_i,
    output trip_t  trip
);
    localparam int NLIM = T_MAXON - 1;
    localparam int FLIM = T_FAULT - 1;
    localparam int NW   = cnt_w(NLIM);
    localparam int FW   = cnt_w(FLIM);
    localparam logic [NW-1:0] NEND = NW'(NLIM);
    localparam logic [FW-1:0] FEND = FW'(FLIM);

    logic [NW-1:0] on_cnt;
    logic [FW-1:0] flt_cnt;
    logic          active;

    assign active = (st == ST_ON) || (st == ST_OFF);

    qrc_sat_cnt #(.LIMIT(NLIM), .START_FULL(1'b0)) u_on_cnt (
        .clk(clk), .rst(rst), .clr(start_on), .en(st == ST_ON), .cnt(on_cnt)
    );

    // fault timer: any low sample or inactive phase restarts it
    qrc_sat_cnt #(.LIMIT(FLIM), .START_FULL(1'b0)) u_flt_cnt (
        .clk(clk), .rst(rst), .clr(!fault_i || !active), .en(1'b1), .cnt(flt_cnt)
    );

    assign trip.maxon = (st == ST_ON) && (on_cnt == NEND);
    assign trip.fault = active && fault_i && (flt_cnt == FEND);

    assert_fault_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
        !fault_i |=> !trip.fault);
endmodule

// File: rtl/qr_cycle_ctrl.sv
module qr_cycle_ctrl
    import qrc_pkg::*;
#(
    parameter int T_MINPER  = 1600,
    parameter int T_VALLEY  = 40,
    parameter int T_BLANK   = 60,
    parameter int T_NODEMAG = 4000,
    parameter int T_MAXON   = 10000,
    parameter int T_FAULT   = 20000000,
    parameter int T_LATCH   = 2000000,
    parameter int T_RESTART = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic demag_i,
    input  logic ilim_i,
    input  logic fault_i,
    output logic gate_o
);
    localparam int MLIM = T_MINPER - 1;
    localparam int MW   = cnt_w(MLIM);
    localparam logic [MW-1:0] MEND = MW'(MLIM);
    localparam int HMAX = max2(T_LATCH, T_RESTART) - 1;
    localparam int HW   = cnt_w(HMAX);
    localparam logic [HW-1:0] HSAT      = HW'(HMAX);
    localparam logic [HW-1:0] LATCH_END = HW'(T_LATCH - 1);
    localparam logic [HW-1:0] WAIT_END  = HW'(T_RESTART - 1);

    phase_e        state_q, state_d;
    logic          start_on;
    logic          arm_ready;
    logic          mp_done;
    logic [MW-1:0] mp_cnt;
    logic [HW-1:0] hold_q;
    trip_t         trip;

    // minimum period clamp: restarted at every turn-on
    qrc_sat_cnt #(.LIMIT(MLIM), .START_FULL(1'b1)) u_mp_cnt (
        .clk(clk), .rst(rst), .clr(start_on), .en(1'b1), .cnt(mp_cnt)
    );
    assign mp_done = (mp_cnt == MEND);

    qrc_arm #(.T_BLANK(T_BLANK), .T_VALLEY(T_VALLEY), .T_NODEMAG(T_NODEMAG)) u_arm (
        .clk(clk), .rst(rst), .in_off(state_q == ST_OFF), .start_on(start_on),
        .demag_i(demag_i), .ready(arm_ready)
    );

    qrc_guard #(.T_MAXON(T_MAXON), .T_FAULT(T_FAULT)) u_guard (
        .clk(clk), .rst(rst), .st(state_q), .start_on(start_on),
        .fault_i(fault_i), .trip(trip)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (trip.fault)
                    state_d = ST_LATCH;
                else if (arm_ready && mp_done)
                    state_d = ST_ON;
            end
            ST_ON: begin
                if (trip.fault)
                    state_d = ST_LATCH;
                else if (ilim_i)
                    state_d = ST_OFF;
                else if (trip.maxon)
                    state_d = ST_LATCH;
            end
            ST_LATCH: if (hold_q == LATCH_END) state_d = ST_WAIT;
            ST_WAIT:  if (hold_q == WAIT_END)  state_d = ST_ON;
            default:  state_d = ST_WAIT;
        endcase
    end

    assign start_on = (state_d == ST_ON) && (state_q != ST_ON);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                hold_q <= '0;
            else if (hold_q != HSAT)
                hold_q <= hold_q + 1'b1;
        end
    end

    assign gate_o = (state_q == ST_ON);

    assert_minper_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_o) && ($past(state_q) == ST_OFF)) |-> $past(mp_done));

    assert_ilim_off_R3: assert property (@(posedge clk) disable iff (rst)
        (gate_o && ilim_i) |=> !gate_o);

    assert_maxon_R7: assert property (@(posedge clk) disable iff (rst)
        (gate_o && trip.maxon && !ilim_i) |=> (state_q == ST_LATCH));

    assert_fault_R8: assert property (@(posedge clk) disable iff (rst)
        trip.fault |=> (state_q == ST_LATCH));

    assert_latch_seq_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LATCH) |=> (state_q == ST_LATCH || state_q == ST_WAIT));

    assert_wait_seq_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |=> (state_q == ST_WAIT || state_q == ST_ON));
endmodule

// File: tb/qr_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module qr_cycle_ctrl_bench;
    localparam int MINPER  = 24;
    localparam int VALLEY  = 3;
    localparam int BLANK   = 4;
    localparam int NODEMAG = 40;
    localparam int MAXON   = 12;
    localparam int FAULT   = 10;
    localparam int LATCH   = 20;
    localparam int RESTART = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic demag = 1'b0;
    logic ilim = 1'b0;
    logic fault = 1'b0;
    logic gate;

    always #2.5 clk = ~clk;

    qr_cycle_ctrl #(
        .T_MINPER(MINPER), .T_VALLEY(VALLEY), .T_BLANK(BLANK), .T_NODEMAG(NODEMAG),
        .T_MAXON(MAXON), .T_FAULT(FAULT), .T_LATCH(LATCH), .T_RESTART(RESTART)
    ) u_qr_cycle_ctrl (
        .clk(clk), .rst(rst), .demag_i(demag), .ilim_i(ilim), .fault_i(fault), .gate_o(gate)
    );

    typedef struct {
        int    at;
        string req;
    } exp_t;

    exp_t expq[$];
    exp_t e_cur;
    int   cyc = 0;
    int   nchk = 0;
    int   nerr = 0;
    int   last_fall = -1;
    bit   prev_g = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input int at, input string req);
        exp_t x;
        x.at  = at;
        x.req = req;
        expq.push_back(x);
    endtask

    task automatic wait_to(input int e);
        while (cyc < e) @(negedge clk);
        #1;
    endtask

    // monitor: pops the expected rise edge for every observed turn-on
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (gate && !prev_g) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected gate rise at edge", cyc, -1);
                end else begin
                    e_cur = expq.pop_front();
                    chk(cyc == e_cur.at, e_cur.req, "gate rise edge", cyc, e_cur.at);
                end
            end
            if (!gate && prev_g) last_fall = cyc;
            prev_g = gate;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R1", "watchdog expired at edge", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int r;
        int f;
        int t;
        int c0;

        // R1: reset and first pulse
        repeat (3) @(negedge clk);
        #1;
        chk(gate == 1'b0, "R1", "gate during reset", int'(gate), 0);
        c0 = cyc;
        rst = 1'b0;
        r = c0 + RESTART;
        push(r, "R1");

        // R3: current limit ends the on-time
        wait_to(r + 2);
        chk(gate == 1'b1, "R3", "gate before limit", int'(gate), 1);
        ilim = 1'b1;
        wait_to(r + 3);
        ilim = 1'b0;
        f = r + 3;
        chk(last_fall == f, "R3", "fall edge", last_fall, f);

        // R2: early detect, minimum period decides the turn-on
        wait_to(f + 4);
        demag = 1'b1;
        wait_to(f + 5);
        demag = 1'b0;
        push(r + MINPER, "R2");
        r = r + MINPER;

        // R5: detect during on-time and blanking must be ignored
        wait_to(r);
        demag = 1'b1;
        ilim = 1'b1;
        wait_to(r + 1);
        ilim = 1'b0;
        wait_to(r + 1 + BLANK);
        demag = 1'b0;
        wait_to(r + 29);
        demag = 1'b1;
        wait_to(r + 30);
        demag = 1'b0;
        push(r + 30 + VALLEY, "R5");
        r = r + 30 + VALLEY;

        // R4: late detect, valley delay decides the turn-on
        wait_to(r + 1);
        ilim = 1'b1;
        wait_to(r + 2);
        ilim = 1'b0;
        wait_to(r + 39);
        demag = 1'b1;
        wait_to(r + 40);
        demag = 1'b0;
        push(r + 40 + VALLEY, "R4");
        r = r + 40 + VALLEY;

        // R6: no detect, watchdog forces the turn-on
        wait_to(r + 1);
        ilim = 1'b1;
        wait_to(r + 2);
        ilim = 1'b0;
        push(r + 2 + NODEMAG + VALLEY, "R6");
        r = r + 2 + NODEMAG + VALLEY;

        // R7: maximum on-time, then R9 latch-off with stray inputs
        wait_to(r + MAXON - 1);
        chk(gate == 1'b1, "R7", "gate one edge before limit", int'(gate), 1);
        wait_to(r + MAXON);
        chk(last_fall == r + MAXON, "R7", "max on-time fall edge", last_fall, r + MAXON);
        t = r + MAXON;
        push(t + LATCH + RESTART, "R9");
        wait_to(t + 2);
        demag = 1'b1;
        ilim = 1'b1;
        wait_to(t + 3);
        demag = 1'b0;
        ilim = 1'b0;
        wait_to(t + LATCH + 1);
        demag = 1'b1;
        ilim = 1'b1;
        wait_to(t + LATCH + 2);
        demag = 1'b0;
        ilim = 1'b0;
        r = t + LATCH + RESTART;

        // R8: short burst does not trip, full burst trips while off
        wait_to(r);
        fault = 1'b1;
        wait_to(r + 1);
        ilim = 1'b1;
        wait_to(r + 2);
        ilim = 1'b0;
        wait_to(r + FAULT - 1);
        fault = 1'b0;
        wait_to(r + FAULT);
        fault = 1'b1;
        wait_to(r + 2 * FAULT);
        fault = 1'b0;
        t = r + 2 * FAULT;
        push(t + LATCH + RESTART, "R8");
        r = t + LATCH + RESTART;

        // R8: fault trip during the on-time
        wait_to(r);
        fault = 1'b1;
        wait_to(r + FAULT - 1);
        chk(gate == 1'b1, "R8", "gate before fault trip", int'(gate), 1);
        wait_to(r + FAULT);
        fault = 1'b0;
        chk(last_fall == r + FAULT, "R8", "fault trip fall edge", last_fall, r + FAULT);
        t = r + FAULT;
        push(t + LATCH + RESTART, "R9");

        wait_to(t + LATCH + RESTART + 3);
        chk(expq.size() == 0, "R9", "pending expected rises", expq.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule